// File: doc/BRIEF.md
# Port Lookup-Table Logic Fabric

This block sits between an eight-lane peripheral-side signal bus and an eight-pin I/O port. It is built from eight 3-input lookup tables. Each table picks its three inputs from the pin lanes, from the stored state bits of the tables, or from the peripheral data lanes. With it, firmware can invert a signal, move a peripheral output to another pin, copy one signal to several pins, combine signals, or run a small state machine such as a counter without any CPU help.

Every pin lane and every data lane has a mode. A lane in bypass passes signals straight through without involving the fabric. While the global enable is low, all lanes act as bypass, so the port behaves as if the block were absent. Configuration is loaded through a write-only address/data port while the fabric is disabled. Any table can be set to registered mode. A registered table holds one state bit, and that bit updates on the rising edge of one chosen data lane, which serves as the fabric clock.

Top module: `port_lut_fabric`

## Requirements
- R1: The enable is bit 0 of address 0. While it is low, every lane behaves as bypass: pad_o equals data_i, pad_oe_o equals periph_oe_i, and data_o equals pad_i. After reset, the enable is low and all modes are bypass.
- R2: Pin lane modes are 2-bit codes: 0 bypass, 1 input, 2 output, 3 none. They are set at address 1, with lane n in bits [2n+1:2n]. In output mode, lane n drives pad_o[n] from table n with pad_oe_o[n]=1. In input mode, pad_i[n] feeds the pin group, and pad_o[n]=0 with pad_oe_o[n]=0. In none mode, pad_o[n]=0 and pad_oe_o[n]=0.
- R3: Data lane modes use the same codes and are set at address 2. Output mode drives data_o[n] from table n. Input mode feeds data_i[n] into the data group and gives data_o[n]=0. None mode gives data_o[n]=0. Bypass gives data_o[n]=pad_i[n].
- R4: Table n is set at address 8+n. Bits [7:0] hold the truth table. Input k is set by a 5-bit selector at bits [12+5k:8+5k]: the lower 3 bits give the lane, and the upper 2 bits give the group (0 pin, 1 state, 2 data, 3 constant 0). The combinational output is truth-table bit {in2,in1,in0}. A table with all three inputs tied to one signal and truth table 0x80 passes that signal through, and 0x01 inverts it.
- R5: Address 0 bits [3:1] select the clock lane, and bits [15:8] set registered mode per table. A registered table loads its truth-table result on each rising edge of data_i at the clock lane. It drives its stored bit as its output and into the state group. The asynchronous reset clears the stored bit.
- R6: While the enable is high, writes to addresses other than 0 have no effect. A write to address 0 then changes only the enable bit.
- R7: Setting the enable is refused, and it stays low, if any table whose pin lane or data lane is in output mode selects the clock lane from the data group.
- R8: Three registered tables with truth tables for bit k of (state+1), fed from state lanes 0, 1 and 2, count up by one on each clock-lane edge and wrap from 7 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Configuration clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 4 | Configuration address |
| cfg_wdata_i | input | 23 | Configuration write data |
| data_i | input | 8 | Peripheral-side signals toward the port |
| periph_oe_i | input | 8 | Peripheral output enables used in bypass |
| data_o | output | 8 | Signals returned to the peripheral side |
| pad_i | input | 8 | Pad input values |
| pad_o | output | 8 | Pad output values |
| pad_oe_o | output | 8 | Pad output enables |

## Verification
Each scenario is compared with a behavioural model of the lane and table rules, and then with explicit expected values. An inversion and a pass-through from a data lane to a different pin show whether the selector group and lane decoding are right and whether the truth table is indexed in the right order. All eight combinations of a 3-input odd-parity function reveal any swapped input weights. A counter run over ten clock-lane edges shows whether the state feedback works, whether the stored bits have the right weights, and whether the count wraps from 7 to 0. A configuration that routes the clock lane to an output must leave the port in bypass, while the same routing with another clock lane must be accepted.

// File: rtl/port_lut_pkg.sv
package port_lut_pkg;
  parameter int unsigned NUM_LANES = 8;
  parameter int unsigned LUT_IN    = 3;

  localparam int unsigned LANE_W    = $clog2(NUM_LANES);
  localparam int unsigned TBL_W     = 2 ** LUT_IN;
  localparam int unsigned SEL_W     = 2 + LANE_W;
  localparam int unsigned LUT_CFG_W = TBL_W + LUT_IN * SEL_W;
  localparam int unsigned CFG_DW    = LUT_CFG_W;
  localparam int unsigned CFG_AW    = LANE_W + 1;
  localparam int unsigned REG_LSB   = 8;

  localparam logic [1:0] LM_BYPASS = 2'd0;
  localparam logic [1:0] LM_INPUT  = 2'd1;
  localparam logic [1:0] LM_OUTPUT = 2'd2;
  localparam logic [1:0] LM_NONE   = 2'd3;

  localparam logic [1:0] SG_PIN   = 2'd0;
  localparam logic [1:0] SG_STATE = 2'd1;
  localparam logic [1:0] SG_DATA  = 2'd2;

  typedef struct packed {
    logic [1:0]        grp;
    logic [LANE_W-1:0] lane;
  } lut_sel_t;

  typedef struct packed {
    lut_sel_t [LUT_IN-1:0] sel;
    logic [TBL_W-1:0]      tbl;
  } lut_cfg_t;

  // Clock lane reaching a driven output through a data-group select
  function automatic logic clk_hazard(input logic [NUM_LANES-1:0][1:0] pm,
                                      input logic [NUM_LANES-1:0][1:0] dm,
                                      input lut_cfg_t [NUM_LANES-1:0] cfg,
                                      input logic [LANE_W-1:0] clk_lane);
    logic hz;
    hz = 1'b0;
    for (int n = 0; n < NUM_LANES; n++) begin
      for (int k = 0; k < LUT_IN; k++) begin
        if ((pm[n] == LM_OUTPUT || dm[n] == LM_OUTPUT) &&
            cfg[n].sel[k].grp == SG_DATA && cfg[n].sel[k].lane == clk_lane)
          hz = 1'b1;
      end
    end
    return hz;
  endfunction
endpackage

// File: rtl/port_lut_cfg.sv
module port_lut_cfg
  import port_lut_pkg::*;
(
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              we_i,
  input  logic [CFG_AW-1:0]                 addr_i,
  input  logic [CFG_DW-1:0]                 wdata_i,
  output logic                              en_o,
  output logic [LANE_W-1:0]                 clk_sel_o,
  output logic [NUM_LANES-1:0]              reg_mode_o,
  output logic [NUM_LANES-1:0][1:0]         pin_mode_o,
  output logic [NUM_LANES-1:0][1:0]         dat_mode_o,
  output lut_cfg_t [NUM_LANES-1:0]          lut_cfg_o
);
  logic                      en_q;
  logic [LANE_W-1:0]         clk_sel_q;
  logic [NUM_LANES-1:0]      reg_mode_q;
  logic [NUM_LANES-1:0][1:0] pin_mode_q, dat_mode_q;
  lut_cfg_t [NUM_LANES-1:0]  lut_cfg_q;
  logic                      hazard_w;

  assign hazard_w = clk_hazard(pin_mode_q, dat_mode_q, lut_cfg_q, wdata_i[LANE_W:1]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q       <= 1'b0;
      clk_sel_q  <= '0;
      reg_mode_q <= '0;
      pin_mode_q <= '0;
      dat_mode_q <= '0;
      lut_cfg_q  <= '0;
    end else if (we_i) begin
      if (addr_i == '0) begin
        if (!en_q) begin
          clk_sel_q  <= wdata_i[LANE_W:1];
          reg_mode_q <= wdata_i[REG_LSB +: NUM_LANES];
          en_q       <= wdata_i[0] && !hazard_w;
        end else begin
          en_q <= wdata_i[0];
        end
      end else if (!en_q) begin
        if (addr_i[CFG_AW-1])
          lut_cfg_q[addr_i[LANE_W-1:0]] <= lut_cfg_t'(wdata_i[LUT_CFG_W-1:0]);
        else if (addr_i == CFG_AW'(1))
          pin_mode_q <= wdata_i[2*NUM_LANES-1:0];
        else if (addr_i == CFG_AW'(2))
          dat_mode_q <= wdata_i[2*NUM_LANES-1:0];
      end
    end
  end

  assign en_o       = en_q;
  assign clk_sel_o  = clk_sel_q;
  assign reg_mode_o = reg_mode_q;
  assign pin_mode_o = pin_mode_q;
  assign dat_mode_o = dat_mode_q;
  assign lut_cfg_o  = lut_cfg_q;
endmodule

// File: rtl/port_lut_cell.sv
module port_lut_cell
  import port_lut_pkg::*;
(
  input  logic                 fab_clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic                 reg_i,
  input  lut_cfg_t             cfg_i,
  input  logic [NUM_LANES-1:0] pin_grp_i,
  input  logic [NUM_LANES-1:0] st_grp_i,
  input  logic [NUM_LANES-1:0] dat_grp_i,
  output logic                 y_o,
  output logic                 q_o
);
  logic [LUT_IN-1:0] idx;
  logic              comb;
  logic              q;

  always_comb begin
    for (int k = 0; k < LUT_IN; k++) begin
      case (cfg_i.sel[k].grp)
        SG_PIN:   idx[k] = pin_grp_i[cfg_i.sel[k].lane];
        SG_STATE: idx[k] = st_grp_i[cfg_i.sel[k].lane];
        SG_DATA:  idx[k] = dat_grp_i[cfg_i.sel[k].lane];
        default:  idx[k] = 1'b0;
      endcase
    end
    comb = cfg_i.tbl[idx];
  end

  always_ff @(posedge fab_clk_i or negedge rst_ni) begin
    if (!rst_ni)                q <= 1'b0;
    else if (!en_i || !reg_i)   q <= 1'b0;
    else                        q <= comb;
  end

  assign y_o = reg_i ? q : comb;
  assign q_o = q;
endmodule

// File: rtl/port_lane_io.sv
module port_lane_io
  import port_lut_pkg::*;
(
  input  logic                      en_i,
  input  logic [NUM_LANES-1:0][1:0] pin_mode_i,
  input  logic [NUM_LANES-1:0][1:0] dat_mode_i,
  input  logic [NUM_LANES-1:0]      lut_y_i,
  input  logic [NUM_LANES-1:0]      pad_i,
  input  logic [NUM_LANES-1:0]      data_i,
  input  logic [NUM_LANES-1:0]      periph_oe_i,
  output logic [NUM_LANES-1:0]      pad_o,
  output logic [NUM_LANES-1:0]      pad_oe_o,
  output logic [NUM_LANES-1:0]      data_o,
  output logic [NUM_LANES-1:0]      pin_grp_o,
  output logic [NUM_LANES-1:0]      dat_grp_o
);
  for (genvar n = 0; n < NUM_LANES; n++) begin : g_lane
    logic [1:0] pm, dm;
    assign pm = en_i ? pin_mode_i[n] : LM_BYPASS;
    assign dm = en_i ? dat_mode_i[n] : LM_BYPASS;

    always_comb begin
      case (pm)
        LM_BYPASS: begin pad_o[n] = data_i[n];  pad_oe_o[n] = periph_oe_i[n]; end
        LM_OUTPUT: begin pad_o[n] = lut_y_i[n]; pad_oe_o[n] = 1'b1; end
        default:   begin pad_o[n] = 1'b0;       pad_oe_o[n] = 1'b0; end
      endcase
      case (dm)
        LM_BYPASS: data_o[n] = pad_i[n];
        LM_OUTPUT: data_o[n] = lut_y_i[n];
        default:   data_o[n] = 1'b0;
      endcase
    end

    assign pin_grp_o[n] = (pm == LM_INPUT) & pad_i[n];
    assign dat_grp_o[n] = (dm == LM_INPUT) & data_i[n];
  end
endmodule

// File: rtl/port_lut_fabric.sv
module port_lut_fabric
  import port_lut_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_we_i,
  input  logic [CFG_AW-1:0]    cfg_addr_i,
  input  logic [CFG_DW-1:0]    cfg_wdata_i,
  input  logic [NUM_LANES-1:0] data_i,
  input  logic [NUM_LANES-1:0] periph_oe_i,
  output logic [NUM_LANES-1:0] data_o,
  input  logic [NUM_LANES-1:0] pad_i,
  output logic [NUM_LANES-1:0] pad_o,
  output logic [NUM_LANES-1:0] pad_oe_o
);
  logic                      en;
  logic [LANE_W-1:0]         clk_sel;
  logic [NUM_LANES-1:0]      reg_mode;
  logic [NUM_LANES-1:0][1:0] pin_mode, dat_mode;
  lut_cfg_t [NUM_LANES-1:0]  lut_cfg;
  logic [NUM_LANES-1:0]      lut_y, lut_q, pin_grp, dat_grp;
  logic                      fab_clk;

  port_lut_cfg u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cfg_we_i),
    .addr_i     (cfg_addr_i),
    .wdata_i    (cfg_wdata_i),
    .en_o       (en),
    .clk_sel_o  (clk_sel),
    .reg_mode_o (reg_mode),
    .pin_mode_o (pin_mode),
    .dat_mode_o (dat_mode),
    .lut_cfg_o  (lut_cfg)
  );

  assign fab_clk = data_i[clk_sel];

  for (genvar n = 0; n < NUM_LANES; n++) begin : g_lut
    port_lut_cell u_lut (
      .fab_clk_i (fab_clk),
      .rst_ni    (rst_ni),
      .en_i      (en),
      .reg_i     (reg_mode[n]),
      .cfg_i     (lut_cfg[n]),
      .pin_grp_i (pin_grp),
      .st_grp_i  (lut_q),
      .dat_grp_i (dat_grp),
      .y_o       (lut_y[n]),
      .q_o       (lut_q[n])
    );
  end

  port_lane_io u_io (
    .en_i        (en),
    .pin_mode_i  (pin_mode),
    .dat_mode_i  (dat_mode),
    .lut_y_i     (lut_y),
    .pad_i       (pad_i),
    .data_i      (data_i),
    .periph_oe_i (periph_oe_i),
    .pad_o       (pad_o),
    .pad_oe_o    (pad_oe_o),
    .data_o      (data_o),
    .pin_grp_o   (pin_grp),
    .dat_grp_o   (dat_grp)
  );
endmodule

// File: rtl/port_lut_fabric_chk.sv
module port_lut_fabric_chk
  import port_lut_pkg::*;
(
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      en,
  input logic [LANE_W-1:0]         clk_sel,
  input logic [NUM_LANES-1:0][1:0] pin_mode,
  input logic [NUM_LANES-1:0][1:0] dat_mode,
  input lut_cfg_t [NUM_LANES-1:0]  lut_cfg,
  input logic [NUM_LANES-1:0]      data_i,
  input logic [NUM_LANES-1:0]      periph_oe_i,
  input logic [NUM_LANES-1:0]      pad_i,
  input logic [NUM_LANES-1:0]      pad_o,
  input logic [NUM_LANES-1:0]      pad_oe_o,
  input logic [NUM_LANES-1:0]      data_o
);
  logic [NUM_LANES-1:0] out_m, quiet_m, dnone_m;
  always_comb begin
    for (int n = 0; n < NUM_LANES; n++) begin
      out_m[n]   = pin_mode[n] == LM_OUTPUT;
      quiet_m[n] = pin_mode[n] == LM_INPUT || pin_mode[n] == LM_NONE;
      dnone_m[n] = dat_mode[n] == LM_INPUT || dat_mode[n] == LM_NONE;
    end
  end

  assert_bypass_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |-> (pad_o == data_i && pad_oe_o == periph_oe_i && data_o == pad_i));

  assert_out_drive_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en |-> ((pad_oe_o & out_m) == out_m));

  assert_quiet_pin_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en |-> ((pad_oe_o & quiet_m) == '0 && (pad_o & quiet_m) == '0));

  assert_data_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en |-> ((data_o & dnone_m) == '0));

  assert_cfg_frozen_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en |=> ($stable(pin_mode) && $stable(dat_mode) && $stable(lut_cfg) && $stable(clk_sel)));

  assert_no_hazard_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en |-> !clk_hazard(pin_mode, dat_mode, lut_cfg, clk_sel));
endmodule

bind port_lut_fabric port_lut_fabric_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en          (en),
  .clk_sel     (clk_sel),
  .pin_mode    (pin_mode),
  .dat_mode    (dat_mode),
  .lut_cfg     (lut_cfg),
  .data_i      (data_i),
  .periph_oe_i (periph_oe_i),
  .pad_i       (pad_i),
  .pad_o       (pad_o),
  .pad_oe_o    (pad_oe_o),
  .data_o      (data_o)
);

// File: tb/port_lut_fabric_test.sv
module port_lut_fabric_test;
  import port_lut_pkg::*;

  logic                 clk_i = 1'b0;
  logic                 rst_ni = 1'b0;
  logic                 cfg_we_i = 1'b0;
  logic [CFG_AW-1:0]    cfg_addr_i = '0;
  logic [CFG_DW-1:0]    cfg_wdata_i = '0;
  logic [NUM_LANES-1:0] data_i = '0, periph_oe_i = '0, pad_i = '0;
  logic [NUM_LANES-1:0] data_o, pad_o, pad_oe_o;

  port_lut_fabric uut (.*);

  always #2 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // behavioural model state
  bit       m_en;
  bit [2:0] m_clk;
  bit [7:0] m_reg, m_q;
  bit [1:0] m_pm [8], m_dm [8];
  bit [7:0] m_tbl [8];
  bit [1:0] m_g [8][3];
  bit [2:0] m_l [8][3];

  function automatic bit m_hz(bit [2:0] c);
    for (int n = 0; n < 8; n++)
      for (int k = 0; k < 3; k++)
        if ((m_pm[n] == 2 || m_dm[n] == 2) && m_g[n][k] == 2 && m_l[n][k] == c) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit [7:0] m_comb();
    bit [7:0] pg, dg, r;
    for (int n = 0; n < 8; n++) begin
      pg[n] = m_en && m_pm[n] == 1 && pad_i[n];
      dg[n] = m_en && m_dm[n] == 1 && data_i[n];
    end
    for (int n = 0; n < 8; n++) begin
      bit [2:0] ix;
      for (int k = 0; k < 3; k++)
        case (m_g[n][k])
          0: ix[k] = pg[m_l[n][k]];
          1: ix[k] = m_q[m_l[n][k]];
          2: ix[k] = dg[m_l[n][k]];
          default: ix[k] = 1'b0;
        endcase
      r[n] = m_tbl[n][ix];
    end
    return r;
  endfunction

  function automatic bit [23:0] m_eval();
    bit [7:0] c, po, oe, dout;
    c = m_comb();
    for (int n = 0; n < 8; n++) begin
      bit [1:0] pm, dm;
      bit y;
      pm = m_en ? m_pm[n] : 2'd0;
      dm = m_en ? m_dm[n] : 2'd0;
      y  = m_reg[n] ? m_q[n] : c[n];
      po[n]   = pm == 0 ? data_i[n] : (pm == 2 ? y : 1'b0);
      oe[n]   = pm == 0 ? periph_oe_i[n] : (pm == 2);
      dout[n] = dm == 0 ? pad_i[n] : (dm == 2 ? y : 1'b0);
    end
    return {po, oe, dout};
  endfunction

  task automatic chk_val(string req, string what, logic [23:0] act, logic [23:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic chk_model(string req, string what);
    #1;
    chk_val(req, what, {pad_o, pad_oe_o, data_o}, m_eval());
  endtask

  task automatic cfg_wr(int a, logic [CFG_DW-1:0] d);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_addr_i = CFG_AW'(a); cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    if (a == 0) begin
      if (!m_en) begin
        m_clk = d[3:1]; m_reg = d[15:8];
        m_en  = d[0] && !m_hz(d[3:1]);
      end else m_en = d[0];
    end else if (!m_en) begin
      if (a == 1)      for (int n = 0; n < 8; n++) m_pm[n] = d[2*n +: 2];
      else if (a == 2) for (int n = 0; n < 8; n++) m_dm[n] = d[2*n +: 2];
      else if (a >= 8) begin
        m_tbl[a-8] = d[7:0];
        for (int k = 0; k < 3; k++) begin
          m_l[a-8][k] = d[8+5*k +: 3];
          m_g[a-8][k] = d[11+5*k +: 2];
        end
      end
    end
  endtask

  function automatic logic [CFG_DW-1:0] lut_word(bit [7:0] t, bit [1:0] g0, bit [2:0] l0,
      bit [1:0] g1, bit [2:0] l1, bit [1:0] g2, bit [2:0] l2);
    return CFG_DW'({g2, l2, g1, l1, g0, l0, t});
  endfunction

  task automatic do_reset();
    rst_ni = 1'b0;
    m_en = 0; m_clk = 0; m_reg = 0; m_q = 0;
    for (int n = 0; n < 8; n++) begin
      m_pm[n] = 0; m_dm[n] = 0; m_tbl[n] = 0;
      for (int k = 0; k < 3; k++) begin m_g[n][k] = 0; m_l[n][k] = 0; end
    end
    @(negedge clk_i); @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic fab_edge();
    bit [7:0] c;
    @(negedge clk_i);
    c = m_comb();
    data_i[m_clk] = 1'b1;
    for (int n = 0; n < 8; n++) m_q[n] = m_en && m_reg[n] && c[n];
    @(negedge clk_i);
    data_i[m_clk] = 1'b0;
  endtask

  task automatic t_reset();
    data_i = 8'hA5; periph_oe_i = 8'h3C; pad_i = 8'h5A;
    do_reset();
    #1;
    chk_val("R1", "reset bypass", {pad_o, pad_oe_o, data_o}, {8'hA5, 8'h3C, 8'h5A});
    chk_model("R1", "reset model");
  endtask

  task automatic t_invert();
    do_reset();
    cfg_wr(1, CFG_DW'((1 << 0) | (2 << 10)));
    cfg_wr(13, lut_word(8'h01, 0, 0, 0, 0, 0, 0));
    cfg_wr(0, CFG_DW'(1));
    pad_i = 8'h00; #1;
    chk_val("R2", "invert pad0=0 -> pad5", {7'd0, pad_o[5], 7'd0, pad_oe_o[5], 8'd0}, {7'd0, 1'b1, 7'd0, 1'b1, 8'd0});
    chk_model("R4", "invert model 0");
    pad_i = 8'h01; #1;
    chk_val("R4", "invert pad0=1 -> pad5", {23'd0, pad_o[5]}, 24'd0);
    cfg_wr(13, lut_word(8'hFF, 0, 0, 0, 0, 0, 0));
    #1;
    chk_val("R6", "table write while enabled ignored", {23'd0, pad_o[5]}, 24'd0);
    chk_model("R6", "frozen model");
    cfg_wr(0, CFG_DW'(0));
    data_i = 8'h0F; periph_oe_i = 8'hF0; pad_i = 8'h33; #1;
    chk_val("R1", "disable returns bypass", {pad_o, pad_oe_o, data_o}, {8'h0F, 8'hF0, 8'h33});
  endtask

  task automatic t_remap();
    do_reset();
    // pin2 output, pin7 none; data4 input, data6 output, data7 none, data1 bypass
    cfg_wr(1, CFG_DW'((2 << 4) | (3 << 14)));
    cfg_wr(2, CFG_DW'((1 << 8) | (2 << 12) | (3 << 14)));
    cfg_wr(10, lut_word(8'h80, 2, 4, 2, 4, 2, 4));
    cfg_wr(14, lut_word(8'h80, 2, 4, 2, 4, 2, 4));
    cfg_wr(0, CFG_DW'(1));
    periph_oe_i = 8'hFF; pad_i = 8'hFF;
    for (int v = 0; v < 2; v++) begin
      data_i = v ? 8'h10 : 8'hEF; #1;
      chk_val("R4", "remap data4 -> pad2", {23'd0, pad_o[2]}, {23'd0, v[0]});
      chk_val("R3", "data6 output / data7 none / data4 input",
              {21'd0, data_o[7], data_o[6], data_o[4]}, {21'd0, 1'b0, v[0], 1'b0});
      chk_val("R2", "pin7 none", {22'd0, pad_o[7], pad_oe_o[7]}, 24'd0);
      chk_model("R3", "remap model");
    end
  endtask

  task automatic t_parity();
    do_reset();
    cfg_wr(1, CFG_DW'((1 << 2) | (1 << 6) | (1 << 12) | (2 << 14)));
    cfg_wr(15, lut_word(8'h96, 0, 1, 0, 3, 0, 6));
    cfg_wr(0, CFG_DW'(1));
    for (int v = 0; v < 8; v++) begin
      pad_i = 8'h00;
      pad_i[1] = v[0]; pad_i[3] = v[1]; pad_i[6] = v[2];
      #1;
      chk_val("R4", "odd parity", {23'd0, pad_o[7]}, {23'd0, ^v[2:0]});
      chk_model("R2", "parity model");
    end
  endtask

  task automatic t_counter();
    bit [7:0] tb [3];
    for (int k = 0; k < 3; k++)
      for (int v = 0; v < 8; v++) tb[k][v] = ((v + 1) >> k) & 1;
    for (int pass = 0; pass < 2; pass++) begin
      do_reset();
      data_i = 8'h00;
      cfg_wr(1, CFG_DW'((2 << 0) | (2 << 2) | (2 << 4)));
      cfg_wr(2, CFG_DW'(1 << 10));
      for (int k = 0; k < 3; k++) cfg_wr(8 + k, lut_word(tb[k], 1, 0, 1, 1, 1, 2));
      cfg_wr(0, CFG_DW'(1 | (5 << 1) | (8'h07 << 8)));
      #1;
      chk_val("R5", "count starts at 0", {21'd0, pad_o[2:0]}, 24'd0);
      if (pass == 1) break;
      for (int i = 1; i <= 10; i++) begin
        fab_edge();
        #1;
        chk_val("R8", i == 8 ? "wrap 7->0" : "count step", {21'd0, pad_o[2:0]}, 24'(i % 8));
        chk_model("R5", "counter model");
      end
    end
  endtask

  task automatic t_hazard();
    do_reset();
    cfg_wr(1, CFG_DW'(2 << 6));
    cfg_wr(2, CFG_DW'(1 << 10));
    cfg_wr(11, lut_word(8'h80, 2, 5, 2, 5, 2, 5));
    cfg_wr(0, CFG_DW'(1 | (5 << 1)));
    data_i = 8'h20; periph_oe_i = 8'h00; pad_i = 8'hC3; #1;
    chk_val("R7", "clock to output refused", {pad_o, pad_oe_o, data_o}, {8'h20, 8'h00, 8'hC3});
    cfg_wr(0, CFG_DW'(1 | (4 << 1)));
    #1;
    chk_val("R7", "other clock lane accepted", {22'd0, pad_o[3], pad_oe_o[3]}, 24'd3);
    chk_model("R7", "hazard model");
  endtask

  initial begin
    t_reset();
    t_invert();
    t_remap();
    t_parity();
    t_counter();
    t_hazard();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule